// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a word-wide main-memory port. It keeps a small direct-mapped store of lines. Each line has a valid flag, a dirty flag, a tag and a block of data words. An access that finds its line present finishes in the same cycle it is requested. An access that does not find its line stalls the processor until the line has been brought in.

Stores use write-allocate with write-back. A store miss fetches the block first. The store word then goes into the cache only, and the line is marked dirty. Memory sees a modified line only when that line is evicted. The eviction writes the whole old block back, at the address rebuilt from its stored tag and index, before the refill of the new block begins.

The processor holds a request (`cpu_req`, `cpu_we`, `cpu_addr`, `cpu_wdata`) until `cpu_ready` is high. Memory answers each word with one `mem_ack` pulse after any number of wait cycles.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address splits from low to high into 2 byte-offset bits, BOFF_W block-offset bits, IDX_W index bits and the rest as tag. With the defaults (8-bit address, 8 lines, 1 word), the index is bits [4:2] and the tag is bits [7:5]. The byte-offset bits never change which word is returned.
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_ready` in the same cycle as `cpu_req` and makes no memory request.
- R3: A read miss holds `cpu_ready` low and fetches every word of the block with memory reads. It then returns the requested word and leaves the line valid and clean.
- R4: A write miss fetches the block first. It then stores the word into the cache only, with no memory write for that store, and marks the line dirty.
- R5: A write hit updates only the cached word and marks the line dirty. Later loads of that word return the new value.
- R6: A miss on a valid, dirty line first writes every word of the old block to memory, at ascending block offsets. The address is rebuilt from the stored tag and index. The refill reads start only after this.
- R7: A miss on a valid, clean line, or on an invalid line, issues no memory write.
- R8: Reset clears every valid and dirty flag. After reset, each first access misses, and nothing left over from before the reset is written back.
- R9: During a memory request, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack`. Any acknowledge latency is accepted.
- R10: From an empty default cache, the sequence load 24, load 28, store 60, store 188 runs as follows. The first three accesses miss without a write-back. The last one writes back the stored word at byte address 60 before it refills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | ADDR_W | Memory byte address of the word |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ack |

## Verification
A wrong tag or valid flag shows up at the ports in the cycle of the next access to that index. A false hit raises `cpu_ready` at once and returns a stale word. A false miss produces memory reads that the bench did not predict. A dirty flag that is wrongly clear loses data: the next eviction of that line issues no memory write, and the lost value shows when the address is loaded again. A dirty flag that is wrongly set produces a write-back that was not expected, at the rebuilt victim address, during the very next miss on that index.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int BOFF_W = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << BOFF_W;
  localparam int TAG_W = ADDR_W - 2 - BOFF_W - IDX_W;
  localparam int CW    = (BOFF_W > 0) ? BOFF_W : 1;
  localparam int SW    = $clog2(LINES * WORDS);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_DONE} st_t;

  st_t               st_q;
  logic [CW-1:0]     cnt_q;
  logic [LINES-1:0]  val_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES*WORDS];

  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [CW-1:0]    a_off;
  logic [SW-1:0]    acc_slot, xfer_slot;
  logic             hit, go, last;

  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr[2+BOFF_W +: IDX_W];
  assign a_off = CW'((cpu_addr >> 2) & ADDR_W'(WORDS - 1));

  assign acc_slot  = SW'(a_idx) * SW'(WORDS) + SW'(a_off);
  assign xfer_slot = SW'(a_idx) * SW'(WORDS) + SW'(cnt_q);
  assign last      = (cnt_q == CW'(WORDS - 1));

  assign hit = val_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign go  = cpu_req && ((st_q == S_IDLE && hit) || st_q == S_DONE);

  assign cpu_ready = go;
  assign cpu_rdata = data_q[acc_slot];

  assign mem_req   = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_we    = (st_q == S_WB);
  assign mem_wdata = data_q[xfer_slot];
  assign mem_addr  = ((st_q == S_WB) ? (ADDR_W'({tag_q[a_idx], a_idx}) << (2 + BOFF_W))
                                     : (ADDR_W'({a_tag, a_idx}) << (2 + BOFF_W)))
                     | (ADDR_W'(cnt_q) << 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      val_q   <= '0;
      dirty_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cpu_req && !hit) begin
          cnt_q <= '0;
          st_q  <= (val_q[a_idx] && dirty_q[a_idx]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_ack) begin
          if (last) begin
            cnt_q <= '0;
            st_q  <= S_FILL;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_FILL: if (mem_ack) begin
          if (last) begin
            val_q[a_idx]   <= 1'b1;
            dirty_q[a_idx] <= 1'b0;
            st_q           <= S_DONE;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
      if (go && cpu_we) dirty_q[a_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_ack) begin
      data_q[xfer_slot] <= mem_rdata;
      if (last) tag_q[a_idx] <= a_tag;
    end
    if (go && cpu_we) data_q[acc_slot] <= cpu_wdata;
  end
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_req,
  input logic                 cpu_ready,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 mem_ack,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [DATA_W-1:0]    mem_wdata,
  input logic [(1<<IDX_W)-1:0] val_q,
  input logic [(1<<IDX_W)-1:0] dirty_q,
  input logic [IDX_W-1:0]     a_idx
);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6
  wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> val_q[a_idx] && dirty_q[a_idx]);

  // R2
  ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req && !mem_req);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (val_q == '0) && (dirty_q == '0));
endmodule

bind dm_wb_cache cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .val_q(val_q), .dirty_q(dirty_q), .a_idx(a_idx)
);

// File: tb/sim_dm_wb_cache.sv
`timescale 1ns/1ps
module sim_dm_wb_cache;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;

  dm_wb_cache u0 (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [64];
  logic [31:0] golden [64];
  logic [2:0]  mtag [8];
  logic [7:0]  mval, mdirty;
  int lat = 0, wcnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [7:0]  last_wr_addr;
  logic [31:0] last_wr_data;
  int n_chk = 0, n_fail = 0, cycles = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; wcnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack <= 1; wcnt <= 0;
        if (mem_we) begin
          mem[mem_addr[7:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr; last_wr_data <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[7:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end else wcnt <= wcnt + 1;
    end else mem_ack <= 0;
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic model_reset();
    mval = 0; mdirty = 0;
    for (int i = 0; i < 64; i++) golden[i] = mem[i];
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [31:0] wd);
    logic [5:0] w; logic [2:0] ix, tg; bit ehit, ewb;
    int rd0, wr0, cyc; logic [31:0] got;
    w = a[7:2]; ix = w[2:0]; tg = w[5:3];
    ehit = mval[ix] && mtag[ix] == tg;
    ewb  = !ehit && mval[ix] && mdirty[ix];
    rd0 = rd_cnt; wr0 = wr_cnt; cyc = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #5;
    while (!cpu_ready && cyc < 60) begin @(negedge clk); #5; cyc++; end
    got = cpu_rdata;
    @(posedge clk); #1; cpu_req = 0;
    check(cpu_ready || cyc < 60, "R3 R4 stall never released", cyc, 0);
    if (ehit) check(cyc == 0, "R2 hit not ready in request cycle", cyc, 0);
    else      check(cyc > 0, "R2 R8 miss completed without stall", cyc, 1);
    check(rd_cnt - rd0 == (ehit ? 0 : 1), "R3 R4 refill read count", rd_cnt - rd0, ehit ? 0 : 1);
    check(wr_cnt - wr0 == (ewb ? 1 : 0), "R5 R6 R7 write-back count", wr_cnt - wr0, ewb ? 1 : 0);
    if (ewb) begin
      check(last_wr_addr == {mtag[ix], ix, 2'b00}, "R6 write-back address", last_wr_addr, {mtag[ix], ix, 2'b00});
      check(last_wr_data == golden[{mtag[ix], ix}], "R6 write-back data", last_wr_data, golden[{mtag[ix], ix}]);
    end
    if (!we) check(got == golden[w], "R1 R3 R5 load data", got, golden[w]);
    if (!ehit) begin mval[ix] = 1; mtag[ix] = tg; mdirty[ix] = 0; end
    if (we) begin golden[w] = wd; mdirty[ix] = 1; end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_req, "R8 mem_req idle in reset", mem_req, 0);
    check(!cpu_ready, "R8 cpu_ready low in reset", cpu_ready, 0);
    rst_n = 1;
    // R10 reference sequence
    access(0, 8'd24, 0);
    access(0, 8'd28, 0);
    access(1, 8'd60, 32'hC0FFEE01);
    check(wr_cnt == 0, "R10 R4 no memory write after store 60", wr_cnt, 0);
    access(1, 8'd188, 32'hD00D0002);
    check(wr_cnt == 1, "R10 one write-back on store 188", wr_cnt, 1);
    check(mem[15] == 32'hC0FFEE01, "R10 memory at 60 updated", mem[15], 32'hC0FFEE01);
    check(mem[47] != 32'hD00D0002, "R10 R4 store 188 kept in cache only", mem[47], 0);
    // R5 write hit, R1 byte offset
    access(1, 8'd188, 32'h12345678);
    access(0, 8'd188, 0);
    access(0, 8'd189, 0);
    access(0, 8'd191, 0);
    // R7 clean victim
    access(0, 8'd24, 0);
    access(0, 8'd56, 0);
    // R9 latency sweep over all words
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int k = 0; k < 160; k++)
        access(k % 3 == 0, 8'(((k * 37 + l * 11) % 64) * 4 + (k % 4)), k * 32'h9E3779B1 ^ l);
    end
    // R8 reset drops dirty lines without write-back
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    model_reset();
    for (int j = 0; j < 64; j++) access(0, 8'(j * 4), 0);
    check(wr_cnt >= 1, "R6 sweep produced write-backs", wr_cnt, 1);
    summary();
  end
endmodule